// File: doc/BRIEF.md
# Bitmap PID Packet Filter

This block sits on a transport stream byte path and decides, per packet, whether a packet travels on or disappears. Each packet arrives as a run of bytes whose first byte is flagged. The first eight bytes are packed into a 64-bit big-endian word. A programmable slice of that word (a bit offset and a bit count) gives the packet identifier. The identifier then selects one bit of an internal bitmap with one bit per possible identifier. A set bit forwards the packet; a clear bit drops it.

Bytes are queued inside the block until the verdict for their packet exists. The verdict is then applied from the packet's first byte onward. Dropped packets are discarded at full rate, so the input never has to wait. A host writes the bitmap as 32-bit words through a simple write port. A global switch, and any configuration that cannot describe a valid slice, make the block forward everything. Two counters report how many packets were forwarded and how many were dropped.

Top module: `pid_filter`

## Requirements
- R1: The header word places packet byte 0 in bits 63:56 and byte 7 in bits 7:0. The identifier is bits [cfg_offset+cfg_numbits-1 : cfg_offset] of that word, zero-extended to 13 bits. The defaults are offset 40 and 13 bits.
- R2: A host write with `bmp_we`=1 stores `bmp_wdata` in bitmap word `bmp_addr`. The bit for identifier p is bit p%32 of word p/32. There are 256 words, covering 8192 identifiers.
- R3: With filtering active and a valid slice, a packet is forwarded only when its bitmap bit is 1. A dropped packet produces no output byte.
- R4: With `cfg_filt_en`=0, every packet is forwarded whatever the bitmap holds.
- R5: A bit count of 0 or above 13, or an offset plus bit count above 64, forwards every packet.
- R6: With filtering active and a bitmap that is all zero, no packet is forwarded.
- R7: A forwarded packet leaves in order with its bytes unchanged. `out_sop` is set on byte 0 and `out_last` on byte PKT_LEN-1.
- R8: A bitmap write presented in the same cycle as a packet's byte 7, or earlier, decides that packet. A write presented in any later cycle only affects later packets.
- R9: `fwd_count` rises by one for each forwarded packet and `drop_count` by one for each dropped packet. The two never rise in the same cycle.
- R10: After reset, `out_valid` is 0 and both counters are 0.
- R11: Packets may arrive back to back at one byte per cycle, or with idle cycles between bytes. No byte is lost and the internal queues never overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is byte 0 of a packet |
| in_data | input | 8 | Input byte |
| cfg_filt_en | input | 1 | 1 = filter by bitmap, 0 = forward all |
| cfg_offset | input | 6 | Bit offset of the identifier slice |
| cfg_numbits | input | 4 | Width of the identifier slice |
| bmp_we | input | 1 | Bitmap word write strobe |
| bmp_addr | input | 8 | Bitmap word address |
| bmp_wdata | input | 32 | Bitmap word data |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is byte 0 of a packet |
| out_last | output | 1 | Output byte is the last byte of a packet |
| out_data | output | 8 | Output byte |
| fwd_count | output | 16 | Forwarded packet count |
| drop_count | output | 16 | Dropped packet count |

## Verification
A host write to the bitmap and the bitmap read for a packet's lookup can fall in the same cycle. The read happens in the cycle after the packet's eighth byte. The bench sets up this collision by writing the word that holds the packet's bit in exactly that cycle. It expects that packet to be dropped and the next packet with the same identifier to be forwarded. A matching write in the cycle of the eighth byte itself must decide the packet it lands in. The two cases pin down on which side of the collision each cycle falls.

// File: rtl/pid_filt_pkg.sv
package pid_filt_pkg;
  localparam int HDR_BYTES = 8;
  localparam int HDR_BITS  = 64;
  localparam int PID_W     = 13;
  localparam int OFF_W     = 6;
  localparam int NB_W      = 4;

  // Forward-everything condition: filter off or a slice that cannot exist.
  function automatic logic cfg_pass_all(input logic en, input logic [OFF_W-1:0] off,
                                        input logic [NB_W-1:0] nb);
    int span;
    span = int'(off) + int'(nb);
    return (!en) || (nb == '0) || (int'(nb) > PID_W) || (span > HDR_BITS);
  endfunction

  // Identifier = word[off+nb-1:off], zero-extended.
  function automatic logic [PID_W-1:0] slice_pid(input logic [HDR_BITS-1:0] w,
                                                 input logic [OFF_W-1:0] off,
                                                 input logic [NB_W-1:0] nb);
    logic [HDR_BITS-1:0] sh;
    logic [PID_W-1:0]    m;
    sh = w >> off;
    if (nb == '0 || int'(nb) > PID_W) m = '0;
    else m = {PID_W{1'b1}} >> (NB_W'(PID_W) - nb);
    return sh[PID_W-1:0] & m;
  endfunction
endpackage

// File: rtl/pid_sync_fifo.sv
module pid_sync_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign rdata = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end
endmodule

// File: rtl/pid_hdr_extract.sv
module pid_hdr_extract
  import pid_filt_pkg::*;
#(
  parameter int PKT_LEN = 188
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sop,
  input  logic [7:0]           in_data,
  input  logic                 cfg_en,
  input  logic [OFF_W-1:0]     cfg_off,
  input  logic [NB_W-1:0]      cfg_nb,
  output logic                 tag_last,
  output logic                 lk_valid,
  output logic [PID_W-1:0]     lk_pid,
  output logic                 lk_pass
);
  localparam int CW = $clog2(PKT_LEN + 1);

  logic [CW-1:0]       cnt, idx;
  logic [HDR_BITS-1:0] hdr, hdr_full;
  logic                hdr_end;

  assign idx      = in_sop ? '0 : cnt;
  assign hdr_full = {hdr[HDR_BITS-9:0], in_data};
  assign hdr_end  = in_valid && (idx == CW'(HDR_BYTES - 1));
  assign tag_last = (idx == CW'(PKT_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= CW'(PKT_LEN);
      hdr      <= '0;
      lk_valid <= 1'b0;
      lk_pid   <= '0;
      lk_pass  <= 1'b0;
    end else begin
      if (in_valid) begin
        cnt <= (idx == CW'(PKT_LEN)) ? idx : idx + 1'b1;
        if (idx < CW'(HDR_BYTES)) hdr <= hdr_full;
      end
      lk_valid <= hdr_end;
      if (hdr_end) begin
        lk_pid  <= slice_pid(hdr_full, cfg_off, cfg_nb);
        lk_pass <= cfg_pass_all(cfg_en, cfg_off, cfg_nb);
      end
    end
  end
endmodule

// File: rtl/pid_bitmap_lookup.sv
module pid_bitmap_lookup #(
  parameter int PID_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [PID_W-6:0]   waddr,
  input  logic [31:0]        wdata,
  input  logic               lk_valid,
  input  logic [PID_W-1:0]   lk_pid,
  input  logic               lk_pass,
  output logic               dec_valid,
  output logic               dec_pass,
  output logic               dec_keep
);
  localparam int WORDS = (2 ** PID_W) / 32;

  logic [31:0] mem [WORDS];
  logic [31:0] rd_word;
  logic [4:0]  sel;

  // Read and write share an edge: the read returns the word before the write.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (lk_valid) begin
      rd_word <= mem[lk_pid[PID_W-1:5]];
      sel     <= lk_pid[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_pass  <= 1'b0;
    end else begin
      dec_valid <= lk_valid;
      if (lk_valid) dec_pass <= lk_pass;
    end
  end

  assign dec_keep = dec_pass | rd_word[sel];
endmodule

// File: rtl/pid_filter.sv
module pid_filter
  import pid_filt_pkg::*;
#(
  parameter int PKT_LEN    = 188,
  parameter int BUF_DEPTH  = 32,
  parameter int DEC_DEPTH  = 4,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  input  logic             cfg_filt_en,
  input  logic [5:0]       cfg_offset,
  input  logic [3:0]       cfg_numbits,
  input  logic             bmp_we,
  input  logic [7:0]       bmp_addr,
  input  logic [31:0]      bmp_wdata,
  output logic             out_valid,
  output logic             out_sop,
  output logic             out_last,
  output logic [7:0]       out_data,
  output logic [CNT_W-1:0] fwd_count,
  output logic [CNT_W-1:0] drop_count
);
  localparam int ENT_W = 10;

  logic             tag_last, lk_valid, lk_pass;
  logic [PID_W-1:0] lk_pid;
  logic             dec_valid, dec_pass, dec_keep;
  logic [ENT_W-1:0] bf_head;
  logic             bf_push, bf_pop, bf_empty, bf_full;
  logic             df_head, df_push, df_pop, df_empty, df_full;
  logic             head_sop, keep_now, cur_keep;

  pid_hdr_extract #(.PKT_LEN(PKT_LEN)) u_hdr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .cfg_en(cfg_filt_en), .cfg_off(cfg_offset), .cfg_nb(cfg_numbits),
    .tag_last(tag_last), .lk_valid(lk_valid), .lk_pid(lk_pid), .lk_pass(lk_pass)
  );

  pid_bitmap_lookup #(.PID_W(PID_W)) u_bmp (
    .clk(clk), .rst_n(rst_n), .we(bmp_we), .waddr(bmp_addr), .wdata(bmp_wdata),
    .lk_valid(lk_valid), .lk_pid(lk_pid), .lk_pass(lk_pass),
    .dec_valid(dec_valid), .dec_pass(dec_pass), .dec_keep(dec_keep)
  );

  assign bf_push = in_valid;
  pid_sync_fifo #(.W(ENT_W), .DEPTH(BUF_DEPTH)) u_bytes (
    .clk(clk), .rst_n(rst_n), .push(bf_push), .wdata({in_sop, tag_last, in_data}),
    .pop(bf_pop), .rdata(bf_head), .empty(bf_empty), .full(bf_full)
  );

  assign df_push = dec_valid;
  pid_sync_fifo #(.W(1), .DEPTH(DEC_DEPTH)) u_verdicts (
    .clk(clk), .rst_n(rst_n), .push(df_push), .wdata(dec_keep),
    .pop(df_pop), .rdata(df_head), .empty(df_empty), .full(df_full)
  );

  // A packet's first byte waits for its verdict; the rest follow it.
  assign head_sop = bf_head[ENT_W-1];
  assign bf_pop   = !bf_empty && (!head_sop || !df_empty);
  assign df_pop   = bf_pop && head_sop;
  assign keep_now = head_sop ? df_head : cur_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_keep   <= 1'b0;
      out_valid  <= 1'b0;
      out_sop    <= 1'b0;
      out_last   <= 1'b0;
      out_data   <= '0;
      fwd_count  <= '0;
      drop_count <= '0;
    end else begin
      if (df_pop) cur_keep <= df_head;
      out_valid <= bf_pop && keep_now;
      out_sop   <= bf_pop && keep_now && head_sop;
      out_last  <= bf_pop && keep_now && bf_head[8];
      if (bf_pop) out_data <= bf_head[7:0];
      if (dec_valid) begin
        if (dec_keep) fwd_count  <= fwd_count + 1'b1;
        else          drop_count <= drop_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pid_filter_chk.sv
module pid_filter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bf_push,
  input logic             bf_full,
  input logic             df_push,
  input logic             df_full,
  input logic             dec_valid,
  input logic             dec_pass,
  input logic             dec_keep,
  input logic [CNT_W-1:0] fwd_count,
  input logic [CNT_W-1:0] drop_count
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    bf_push |-> !bf_full); // R11
  AST_VERDICT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    df_push |-> !df_full); // R11
  AST_PASS_ALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_pass) |-> dec_keep); // R4
  AST_ONE_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fwd_count != $past(fwd_count), drop_count != $past(drop_count)}) <= 1); // R9
  AST_COUNT_ON_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> ($stable(fwd_count) && $stable(drop_count))); // R9
endmodule

bind pid_filter pid_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bf_push(bf_push), .bf_full(bf_full),
  .df_push(df_push), .df_full(df_full), .dec_valid(dec_valid), .dec_pass(dec_pass),
  .dec_keep(dec_keep), .fwd_count(fwd_count), .drop_count(drop_count)
);

// File: tb/sim_pid_filter.sv
module sim_pid_filter;
  localparam int PKT_LEN = 188;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0]  in_data = '0;
  logic        cfg_filt_en = 1'b1;
  logic [5:0]  cfg_offset = 6'd40;
  logic [3:0]  cfg_numbits = 4'd13;
  logic        bmp_we = 1'b0;
  logic [7:0]  bmp_addr = '0;
  logic [31:0] bmp_wdata = '0;
  logic        out_valid, out_sop, out_last;
  logic [7:0]  out_data;
  logic [15:0] fwd_count, drop_count;

  pid_filter #(.PKT_LEN(PKT_LEN)) u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [31:0] bm [256];
  logic [9:0]  expq [$];
  int exp_fwd = 0, exp_drop = 0, pkt_no = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: compare every output byte against the expected queue.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) chk(0, "R3", "unexpected output byte", int'(out_data), -1);
      else begin
        logic [9:0] e;
        e = expq.pop_front();
        chk({out_sop, out_last, out_data} == e, "R7", "output byte/flags", int'({out_sop, out_last, out_data}), int'(e));
      end
    end
  end

  task automatic host_write_now(input int a, input logic [31:0] d);
    bmp_we = 1'b1; bmp_addr = 8'(a); bmp_wdata = d; bm[a] = d;
  endtask

  task automatic host_write(input int a, input logic [31:0] d);
    @(negedge clk); host_write_now(a, d);
    @(negedge clk); bmp_we = 1'b0;
  endtask

  // wr_idx: byte index whose cycle carries a write of wr_d to word wr_a (-1 none)
  task automatic send_pkt(input int pid, input bit gaps, input int wr_idx, input int wr_a, input logic [31:0] wr_d);
    logic [63:0] w, m;
    logic [7:0]  b [PKT_LEN];
    int nb, off;
    bit keep;
    nb = int'(cfg_numbits); off = int'(cfg_offset);
    w = {8'h47, 8'(pkt_no), 8'h3C, 8'hA5, 8'h5A, 8'(pkt_no * 3), 8'hC3, 8'h96};
    if (nb >= 1 && nb <= 13 && off + nb <= 64) begin
      m = ((64'd1 << nb) - 64'd1) << off;
      w = (w & ~m) | ((64'(pid) << off) & m);
    end
    for (int i = 0; i < PKT_LEN; i++)
      b[i] = (i < 8) ? w[63 - 8*i -: 8] : 8'(pkt_no * 7 + i);
    for (int i = 0; i < PKT_LEN; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_data = b[i];
      bmp_we = 1'b0;
      if (i == wr_idx) host_write_now(wr_a, wr_d);
      if (i == 7) begin
        keep = !cfg_filt_en || nb == 0 || nb > 13 || off + nb > 64 || bm[pid >> 5][pid & 31];
        if (keep) begin
          exp_fwd++;
          for (int k = 0; k < PKT_LEN; k++) expq.push_back({k == 0, k == PKT_LEN - 1, b[k]});
        end else exp_drop++;
      end
      if (gaps) begin
        @(negedge clk); in_valid = 1'b0; in_sop = 1'b0; bmp_we = 1'b0;
      end
    end
    @(negedge clk); in_valid = 1'b0; in_sop = 1'b0; bmp_we = 1'b0;
    pkt_no++;
  endtask

  task automatic settle_and_count(input string req);
    repeat (40) @(negedge clk);
    chk(expq.size() == 0, req, "expected bytes still pending", expq.size(), 0);
    chk(fwd_count == 16'(exp_fwd), "R9", {req, " fwd_count"}, int'(fwd_count), exp_fwd);
    chk(drop_count == 16'(exp_drop), "R9", {req, " drop_count"}, int'(drop_count), exp_drop);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
    chk(fwd_count == 0 && drop_count == 0, "R10", "counters after reset", int'({fwd_count, drop_count}), 0);

    for (int a = 0; a < 256; a++) host_write(a, 32'h0);
    // R6: empty bitmap drops everything
    send_pkt(13'h100, 0, -1, 0, 0);
    send_pkt(13'h000, 1, -1, 0, 0);
    settle_and_count("R6");

    // R2/R3: bit p%32 of word p/32
    host_write(8, 32'h0000_0001);     // pid 0x100
    host_write(255, 32'h8000_0000);   // pid 0x1FFF
    send_pkt(13'h100, 0, -1, 0, 0);
    send_pkt(13'h101, 0, -1, 0, 0);
    send_pkt(13'h1FFF, 0, -1, 0, 0);
    send_pkt(13'h1FFE, 1, -1, 0, 0);
    settle_and_count("R2 R3");

    // R1: other slices, including one reaching byte 0 and one at bit 0
    cfg_offset = 6'd0; cfg_numbits = 4'd8;
    host_write(0, 32'h8000_0000);     // pid 0x1F
    send_pkt(13'h1F, 0, -1, 0, 0);
    send_pkt(13'h1E, 0, -1, 0, 0);
    cfg_offset = 6'd51; cfg_numbits = 4'd13;
    send_pkt(13'h1FFF, 0, -1, 0, 0);
    send_pkt(13'h0002, 0, -1, 0, 0);
    settle_and_count("R1");

    // R4: filter disabled
    cfg_offset = 6'd40; cfg_filt_en = 1'b0;
    send_pkt(13'h101, 0, -1, 0, 0);
    send_pkt(13'h1234, 1, -1, 0, 0);
    settle_and_count("R4");
    cfg_filt_en = 1'b1;

    // R5: invalid slice settings forward all
    cfg_numbits = 4'd0;  send_pkt(13'h101, 0, -1, 0, 0);
    cfg_numbits = 4'd14; send_pkt(13'h101, 0, -1, 0, 0);
    cfg_numbits = 4'd8; cfg_offset = 6'd60; send_pkt(13'h3, 0, -1, 0, 0);
    settle_and_count("R5");
    cfg_numbits = 4'd13; cfg_offset = 6'd40;

    // R8: write in byte-7 cycle applies; write one cycle later does not
    send_pkt(13'h0A0, 0, 7, 5, 32'h0000_0001);   // pid 0xA0 -> word 5 bit 0
    send_pkt(13'h0C0, 0, 8, 6, 32'h0000_0001);   // pid 0xC0 -> word 6 bit 0, too late
    send_pkt(13'h0C0, 0, -1, 0, 0);              // now forwarded
    settle_and_count("R8");

    // R11: back-to-back stream mixing kept and dropped packets
    for (int n = 0; n < 8; n++) send_pkt((n % 2) ? 13'h100 : 13'h101, 0, -1, 0, 0);
    settle_and_count("R11");

    // R6 again after clearing the whole bitmap
    for (int a = 0; a < 256; a++) host_write(a, 32'h0);
    send_pkt(13'h100, 0, -1, 0, 0);
    send_pkt(13'h1FFF, 0, -1, 0, 0);
    settle_and_count("R6 cleared");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1;
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule